// File: doc/BRIEF.md
# Low-Speed Modem Call Sequencer

This block is the timing and handshake state machine of a 300-baud frequency-shift modem. It sits between the terminal-side control lines (terminal ready, request to send, ring indication) and the modem's line-side controls (hook relay, transmitter enable and a request to hold the transmitter on its mark tone). It also takes a raw flag from the energy detector and turns it into the qualified carrier-detect and clear-to-send indications that the terminal sees.

A free-running divider makes a one-millisecond tick from the system clock, and that tick paces every interval. Four saturating millisecond counters measure the time spent in the current state, the unbroken time with energy present, the unbroken time with energy absent, and the time since the line was seized. A single state machine covers both directions of a call. On the calling side, the sequence is: seize the line on a dial request, wait for the far tone, hold off, send a mark preamble, then release the terminal to send. On the called side, the sequence is: seize the line on ring, wait out the billing delay, send the mark tone, then qualify the far carrier.

Loss of carrier is handled in two steps. A short loss drops the status lines. A long loss ends the call. A carrier that returns before the long limit restores the status lines at once, with no second preamble. An abort timer releases a line that never hears a proper carrier. Dropping terminal ready always ends the call.

Top module: `modem_call_ctrl`

## Requirements
- R1: After reset the block is idle: off_hook, tx_en, tx_mark, carrier_det and cts are all 0.
- R2: From idle, with dtr=1, answer_mode=0 and rts=1 at a clock edge, off_hook is 1 after that edge while tx_en stays 0. In idle, rts is ignored while answer_mode=1 and ring_n is ignored while answer_mode=0.
- R3: From idle, with dtr=1, answer_mode=1 and ring_n=0 at a clock edge, off_hook goes to 1. After BILLING_MS milliseconds (minus at most one tick) tx_en and tx_mark both go to 1.
- R4: While calling and off hook, energy_det=1 raises carrier_det after the next edge. After ORIG_WAIT_MS ms, tx_en and tx_mark rise. After a further PREAMBLE_MS ms, tx_mark falls and cts rises.
- R5: On the called side, once the mark tone is on, energy present for ANS_QUAL_MS consecutive ms raises carrier_det and cts and lowers tx_mark.
- R6: Once carrier is held, an energy gap that spans more than CD_LOSS_MS tick periods drops carrier_det and cts while tx_en stays 1. A gap spanning CD_LOSS_MS ticks or fewer leaves them unchanged.
- R7: Energy that returns before the hang-up limit restores carrier_det, and cts where it was set, after the next edge, with tx_mark staying 0.
- R8: An energy gap spanning more than HANGUP_MS tick periods returns the block to idle (off_hook=0, tx_en=0).
- R9: dtr=0 at any edge leaves all five outputs 0 after that edge.
- R10: If no qualifying carrier has been reached within ABORT_MS ms of going off hook, on either side, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dtr | input | 1 | Terminal ready; low forces idle |
| rts | input | 1 | Dial request on the calling side |
| ring_n | input | 1 | Ring indication, active low |
| answer_mode | input | 1 | 1 = called side, 0 = calling side |
| energy_det | input | 1 | Raw line energy present |
| off_hook | output | 1 | Line seized |
| tx_en | output | 1 | Transmitter enabled |
| tx_mark | output | 1 | Transmitter forced to the mark tone |
| carrier_det | output | 1 | Qualified carrier present |
| cts | output | 1 | Terminal may send data |

## Verification
The assertions assume that every input is synchronous to clk and steady around the rising edge. They also assume that reset is applied before any line activity, since energy_det and ring_n have no synchroniser inside the block. The bench changes every input only on the falling edge and holds it for whole cycles, so each interval can be measured in exact cycles and compared with a window one tick wide. Energy gaps are driven as whole multiples of the tick period, so the number of ticks each gap spans is fixed whatever the divider phase.

// File: rtl/modem_call_pkg.sv
package modem_call_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_O_SEEK  = 3'd1,
      ST_O_HOLD  = 3'd2,
      ST_O_MARK  = 3'd3,
      ST_O_DATA  = 3'd4,
      ST_A_DELAY = 3'd5,
      ST_A_TONE  = 3'd6,
      ST_A_DATA  = 3'd7
   } call_st_t;

   localparam int NUM_TMR   = 4;
   localparam int TMR_STATE = 0;
   localparam int TMR_HIT   = 1;
   localparam int TMR_MISS  = 2;
   localparam int TMR_SEIZE = 3;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
   parameter int CLKS_PER_MS = 250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLKS_PER_MS < 1) begin : g_bad
         $error("CLKS_PER_MS must be at least 1");
      end
      if (CLKS_PER_MS == 1) begin : g_every
         logic alive_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alive_q <= 1'b0;
            else        alive_q <= 1'b1;
         end
         assign tick = alive_q;
      end else begin : g_div
         localparam int DW = $clog2(CLKS_PER_MS);
         localparam logic [DW-1:0] LAST = DW'(CLKS_PER_MS - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/ms_run_counter.sv
module ms_run_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  count <= '0;
      else if (clr)                count <= '0;
      else if (tick && ~&count)    count <= count + 1'b1;
   end
endmodule

// File: rtl/modem_call_ctrl.sv
module modem_call_ctrl
   import modem_call_pkg::*;
#(
   parameter int CLKS_PER_MS  = 250000,
   parameter int BILLING_MS   = 2100,
   parameter int ORIG_WAIT_MS = 240,
   parameter int PREAMBLE_MS  = 640,
   parameter int ANS_QUAL_MS  = 120,
   parameter int CD_LOSS_MS   = 10,
   parameter int HANGUP_MS    = 230,
   parameter int ABORT_MS     = 14000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dtr,
   input  logic rts,
   input  logic ring_n,
   input  logic answer_mode,
   input  logic energy_det,
   output logic off_hook,
   output logic tx_en,
   output logic tx_mark,
   output logic carrier_det,
   output logic cts
);
   localparam int MAX_MS = max_of(max_of(max_of(BILLING_MS, ORIG_WAIT_MS),
                                         max_of(PREAMBLE_MS, ANS_QUAL_MS)),
                                  max_of(HANGUP_MS, ABORT_MS));
   localparam int CW = $clog2(MAX_MS + 2);

   localparam logic [CW-1:0] K_BILL = CW'(BILLING_MS);
   localparam logic [CW-1:0] K_WAIT = CW'(ORIG_WAIT_MS);
   localparam logic [CW-1:0] K_PRE  = CW'(PREAMBLE_MS);
   localparam logic [CW-1:0] K_QUAL = CW'(ANS_QUAL_MS);
   localparam logic [CW-1:0] K_LOSS = CW'(CD_LOSS_MS);
   localparam logic [CW-1:0] K_HANG = CW'(HANGUP_MS);
   localparam logic [CW-1:0] K_ABRT = CW'(ABORT_MS);

   generate
      if (CD_LOSS_MS < 1 || CD_LOSS_MS >= HANGUP_MS) begin : g_bad_loss
         $error("need 1 <= CD_LOSS_MS < HANGUP_MS");
      end
      if (BILLING_MS < 1 || ORIG_WAIT_MS < 1 || PREAMBLE_MS < 1 ||
          ANS_QUAL_MS < 1 || ABORT_MS < 1) begin : g_bad_interval
         $error("all intervals must be at least 1 ms");
      end
   endgenerate

   logic            tick;
   call_st_t        st_q, st_d;
   logic [NUM_TMR-1:0] tmr_clr;
   logic [CW-1:0]   tmr_cnt [NUM_TMR];

   ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   // Four identical millisecond counters, each with its own clear condition.
   assign tmr_clr[TMR_STATE] = (st_d != st_q);
   assign tmr_clr[TMR_HIT]   = ~energy_det;
   assign tmr_clr[TMR_MISS]  = energy_det;
   assign tmr_clr[TMR_SEIZE] = (st_q == ST_IDLE);

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         ms_run_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .clr   (tmr_clr[i]),
            .count (tmr_cnt[i])
         );
      end
   endgenerate

   logic lost, gone, expired, held;
   assign lost    = (tmr_cnt[TMR_MISS] >  K_LOSS);
   assign gone    = (tmr_cnt[TMR_MISS] >  K_HANG);
   assign expired = (tmr_cnt[TMR_SEIZE] >= K_ABRT);

   always_comb begin
      st_d = st_q;
      if (!dtr) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (answer_mode) begin
                  if (!ring_n) st_d = ST_A_DELAY;
               end else if (rts) begin
                  st_d = ST_O_SEEK;
               end
            end
            ST_O_SEEK: begin
               if (expired)         st_d = ST_IDLE;
               else if (energy_det) st_d = ST_O_HOLD;
            end
            ST_O_HOLD: begin
               if (gone)                                st_d = ST_IDLE;
               else if (tmr_cnt[TMR_STATE] >= K_WAIT)   st_d = ST_O_MARK;
            end
            ST_O_MARK: begin
               if (gone)                                st_d = ST_IDLE;
               else if (tmr_cnt[TMR_STATE] >= K_PRE)    st_d = ST_O_DATA;
            end
            ST_A_DELAY: begin
               if (expired)                             st_d = ST_IDLE;
               else if (tmr_cnt[TMR_STATE] >= K_BILL)   st_d = ST_A_TONE;
            end
            ST_A_TONE: begin
               if (expired)                             st_d = ST_IDLE;
               else if (tmr_cnt[TMR_HIT] >= K_QUAL)     st_d = ST_A_DATA;
            end
            ST_O_DATA, ST_A_DATA: begin
               if (gone) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign held        = (st_q == ST_O_HOLD) || (st_q == ST_O_MARK) ||
                        (st_q == ST_O_DATA) || (st_q == ST_A_DATA);
   assign off_hook    = (st_q != ST_IDLE);
   assign tx_en       = (st_q == ST_O_MARK) || (st_q == ST_O_DATA) ||
                        (st_q == ST_A_TONE) || (st_q == ST_A_DATA);
   assign tx_mark     = (st_q == ST_O_MARK) || (st_q == ST_A_TONE);
   assign carrier_det = held && !lost;
   assign cts         = ((st_q == ST_O_DATA) || (st_q == ST_A_DATA)) && !lost;

endmodule

// File: rtl/modem_call_ctrl_chk.sv
module modem_call_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic dtr,
   input logic energy_det,
   input logic off_hook,
   input logic tx_en,
   input logic tx_mark,
   input logic carrier_det,
   input logic cts
);
   a_r9_dtr_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dtr |=> (!off_hook && !tx_en && !tx_mark && !carrier_det && !cts));

   a_r2_tx_needs_hook: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> off_hook);

   a_r4_mark_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mark |-> (tx_en && !cts));

   a_r5_cts_needs_cd: assert property (@(posedge clk) disable iff (!rst_n)
      cts |-> carrier_det);

   a_r7_cd_rise_on_energy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_det) |-> $past(energy_det));

   a_r2_seize_needs_dtr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(off_hook) |-> $past(dtr));
endmodule

bind modem_call_ctrl modem_call_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dtr         (dtr),
   .energy_det  (energy_det),
   .off_hook    (off_hook),
   .tx_en       (tx_en),
   .tx_mark     (tx_mark),
   .carrier_det (carrier_det),
   .cts         (cts)
);

// File: tb/tb_modem_call_ctrl.sv
module tb_modem_call_ctrl;
   localparam int P    = 4;
   localparam int BILL = 21;
   localparam int OWT  = 6;
   localparam int PRE  = 16;
   localparam int QUAL = 3;
   localparam int LOSS = 2;
   localparam int HANG = 8;
   localparam int ABRT = 60;
   localparam int HOOK = 4, TXEN = 3, MARK = 2, CD = 1, CTS = 0;
   localparam int LIM  = 4 * ABRT * P;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, dtr, rts, ring_n, answer_mode, energy_det;
   logic off_hook, tx_en, tx_mark, carrier_det, cts;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   modem_call_ctrl #(
      .CLKS_PER_MS(P), .BILLING_MS(BILL), .ORIG_WAIT_MS(OWT),
      .PREAMBLE_MS(PRE), .ANS_QUAL_MS(QUAL), .CD_LOSS_MS(LOSS),
      .HANGUP_MS(HANG), .ABORT_MS(ABRT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .dtr(dtr), .rts(rts), .ring_n(ring_n),
      .answer_mode(answer_mode), .energy_det(energy_det),
      .off_hook(off_hook), .tx_en(tx_en), .tx_mark(tx_mark),
      .carrier_det(carrier_det), .cts(cts)
   );

   function automatic logic [4:0] outs();
      return {off_hook, tx_en, tx_mark, carrier_det, cts};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Interval of n ms: observed cycles lie in [(n-1)*P, n*P+2].
   task automatic win(input string req, input int got, input int n);
      chk(got >= (n - 1) * P && got <= n * P + 2, req, got, n * P);
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wait_bit(input int idx, input logic val, output int n);
      n = 0;
      while (outs()[idx] !== val && n < LIM) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic to_idle();
      dtr = 1'b0; rts = 1'b0; ring_n = 1'b1; energy_det = 1'b0;
      cyc(2);
   endtask

   task automatic dial();
      dtr = 1'b1; answer_mode = 1'b0; rts = 1'b1;
      cyc(1);
      rts = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=0", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      bit cd_low;
      rst_n = 1'b0; dtr = 1'b0; rts = 1'b0; ring_n = 1'b1;
      answer_mode = 1'b0; energy_det = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk(outs() == 5'b0, "R1 reset outputs", int'(outs()), 0);

      // R2: wrong trigger for the mode is ignored
      dtr = 1'b1; answer_mode = 1'b1; rts = 1'b1;
      cyc(3);
      chk(outs() == 5'b0, "R2 rts ignored in answer mode", int'(outs()), 0);
      rts = 1'b0; answer_mode = 1'b0; ring_n = 1'b0;
      cyc(3);
      chk(outs() == 5'b0, "R2 ring ignored in originate mode", int'(outs()), 0);
      ring_n = 1'b1;

      // Calling side, full sequence
      dial();
      chk(off_hook == 1'b1, "R2 off hook on dial", off_hook, 1);
      chk(tx_en == 1'b0, "R2 transmitter off while seeking", tx_en, 0);
      energy_det = 1'b1;
      cyc(1);
      chk(carrier_det == 1'b1, "R4 carrier detect on energy", carrier_det, 1);
      chk(tx_en == 1'b0, "R4 no tx during hold-off", tx_en, 0);
      wait_bit(TXEN, 1'b1, n);
      win("R4 hold-off interval", n, OWT);
      chk(tx_mark == 1'b1, "R4 mark preamble", tx_mark, 1);
      wait_bit(CTS, 1'b1, n);
      win("R4 preamble interval", n, PRE);
      chk(tx_mark == 1'b0, "R4 mark released with cts", tx_mark, 0);

      energy_det = 1'b0;
      wait_bit(CD, 1'b0, n);
      win("R6 carrier loss delay", n, LOSS + 1);
      chk(cts == 1'b0, "R6 cts dropped", cts, 0);
      chk(tx_en == 1'b1, "R6 transmitter kept", tx_en, 1);
      energy_det = 1'b1;
      cyc(1);
      chk(carrier_det == 1'b1 && cts == 1'b1, "R7 status restored",
          int'({carrier_det, cts}), 3);
      chk(tx_mark == 1'b0, "R7 no second preamble", tx_mark, 0);
      energy_det = 1'b0;
      wait_bit(HOOK, 1'b0, n);
      win("R8 hang-up delay", n, HANG + 1);
      chk(tx_en == 1'b0, "R8 transmitter off", tx_en, 0);
      to_idle();

      // Called side
      dtr = 1'b1; answer_mode = 1'b1; ring_n = 1'b0;
      cyc(1);
      ring_n = 1'b1;
      chk(off_hook == 1'b1, "R3 off hook on ring", off_hook, 1);
      chk(tx_en == 1'b0, "R3 silent during billing delay", tx_en, 0);
      wait_bit(TXEN, 1'b1, n);
      win("R3 billing delay", n, BILL);
      chk(tx_mark == 1'b1, "R3 answer tone is mark", tx_mark, 1);
      energy_det = 1'b1;
      wait_bit(CTS, 1'b1, n);
      win("R5 carrier qualification", n, QUAL);
      chk(carrier_det == 1'b1 && tx_mark == 1'b0, "R5 cd on mark off",
          int'({carrier_det, tx_mark}), 2);

      dtr = 1'b0;
      cyc(1);
      chk(outs() == 5'b0, "R9 dtr drop forces idle", int'(outs()), 0);
      to_idle();

      // R10: abort on both sides
      dial();
      wait_bit(HOOK, 1'b0, n);
      win("R10 abort while calling", n, ABRT);
      cyc(3);
      chk(outs() == 5'b0, "R10 stays idle after abort", int'(outs()), 0);
      to_idle();
      dtr = 1'b1; answer_mode = 1'b1; ring_n = 1'b0;
      cyc(1);
      ring_n = 1'b1;
      wait_bit(HOOK, 1'b0, n);
      win("R10 abort while answering", n, ABRT);
      to_idle();

      // Sweep of gap lengths in whole tick periods
      for (int g = 1; g <= HANG + 1; g++) begin
         dial();
         energy_det = 1'b1;
         wait_bit(CTS, 1'b1, n);
         energy_det = 1'b0;
         cd_low = 1'b0;
         repeat (g * P) begin
            @(negedge clk);
            if (!carrier_det) cd_low = 1'b1;
         end
         energy_det = 1'b1;
         cyc(2);
         chk(cd_low == (g > LOSS), "R6 gap sweep cd drop", cd_low, int'(g > LOSS));
         chk(off_hook == (g <= HANG), "R8 gap sweep hang-up", off_hook, int'(g <= HANG));
         if (g <= HANG)
            chk(carrier_det && cts, "R7 gap sweep recovery",
                int'({carrier_det, cts}), 3);
         to_idle();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule